// File: doc/BRIEF.md
# Two-Stream Ready-Steered Slot Router

The router stands between a compressed-code store and two stream decoders that run side by side. Every storage word it accepts carries two 4-bit slots. Each slot lands in one of two per-decoder bit buffers. The buffers are left aligned, so the oldest bit sits at the most significant position of the window seen by its decoder.

The steering is not fixed. It follows the same rule the offline packer used when it merged the two compressed streams. A decoder whose buffer already holds enough bits to decode one item does not need more yet, so both slots of the word go to the other buffer. When both buffers are short, or both are well fed, each buffer takes one slot. Because the packer and the router make the same choice, the merged image needs no steering bits.

Each decoder reports how many bits it used in the current cycle. Those bits leave the head of its buffer in the same cycle that new bits are appended. At every branch target a restart input empties both buffers, so placement begins afresh for the next block of code.

Top module: `dual_slot_router`

## Requirements
- R1: While `rst_n` is low, both fills are 0, both windows are 0 and both ready flags are low.
- R2: While `restart` is high, `word_ready` is low. On the next cycle both fills and both windows are 0.
- R3: `rdy0` is high exactly when `fill0` is at least 5. `rdy1` is high exactly when `fill1` is at least 5.
- R4: An accepted word is steered by the ready flags held before the word arrives. Slot 1 is `word_data[7:4]` and slot 2 is `word_data[3:0]`. When neither flag is high, slot 1 is appended to buffer 0 and slot 2 to buffer 1.
- R5: When only `rdy1` is high, both slots are appended to buffer 0, slot 1 first. Buffer 1 receives nothing.
- R6: When only `rdy0` is high, both slots are appended to buffer 1, slot 1 first. Buffer 0 receives nothing.
- R7: When both flags are high, the word is split as in R4.
- R8: Window bit 15 is the oldest bit. In one cycle, `takeN` bits leave the top of window N and the rest shift up. New bits land directly below the bits that remain, and every bit below the fill is 0.
- R9: A `takeN` greater than `fillN` removes only `fillN` bits.
- R10: `word_ready` is low when either destination would hold more than 16 bits after that cycle's removal and append. A cycle with no accepted word, no restart and zero takes leaves both windows and fills unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Branch-target restart; empties both buffers |
| word_valid | input | 1 | A storage word is offered |
| word_data | input | 8 | Storage word; slot 1 in the upper 4 bits |
| word_ready | output | 1 | The offered word is taken this cycle |
| take0 | input | 3 | Bits consumed from buffer 0 this cycle |
| take1 | input | 3 | Bits consumed from buffer 1 this cycle |
| win0 | output | 16 | Buffer 0 window, oldest bit at the MSB |
| win1 | output | 16 | Buffer 1 window, oldest bit at the MSB |
| fill0 | output | 5 | Valid bit count in buffer 0 |
| fill1 | output | 5 | Valid bit count in buffer 1 |
| rdy0 | output | 1 | Buffer 0 holds a full decode length |
| rdy1 | output | 1 | Buffer 1 holds a full decode length |

## Verification
`word_ready` is combinational in the offered word, the takes and the registered fills. The bench therefore samples it 1 ns after driving each vector, before the edge. Windows, fills and ready flags change on the rising edge that takes the vector. They are sampled at the following falling edge, one cycle after the stimulus, and the table holds the state expected at that point.

The vector order drives each buffer across the 4-to-5 bit ready threshold, so every steering case occurs. A rejected word and an idle cycle are each followed by a state compare. A restart arriving together with a valid word and an oversized take on an empty buffer are each checked on the cycle that follows them.

// File: rtl/dual_slot_router.sv
module dual_slot_router #(
  parameter int SLOT_W = 4,
  parameter int BUF_W  = 16,
  parameter int NEED   = 5,
  parameter int TW     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        restart,
  input  logic                        word_valid,
  input  logic [2*SLOT_W-1:0]         word_data,
  output logic                        word_ready,
  input  logic [TW-1:0]               take0,
  input  logic [TW-1:0]               take1,
  output logic [BUF_W-1:0]            win0,
  output logic [BUF_W-1:0]            win1,
  output logic [$clog2(BUF_W+1)-1:0]  fill0,
  output logic [$clog2(BUF_W+1)-1:0]  fill1,
  output logic                        rdy0,
  output logic                        rdy1
);
  localparam int PAIR = 2 * SLOT_W;
  localparam int FW   = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] win_q  [2];
  logic [FW-1:0]    fill_q [2];
  logic [TW-1:0]    take   [2];
  logic [FW-1:0]    tk     [2];
  logic [FW-1:0]    rem    [2];
  logic [FW:0]      len    [2];
  logic [PAIR-1:0]  bits   [2];
  logic             rdy    [2];
  logic             room   [2];

  logic [SLOT_W-1:0] s1, s2;
  logic only0, only1, acc;

  assign s1 = word_data[PAIR-1:SLOT_W];
  assign s2 = word_data[SLOT_W-1:0];
  assign take[0] = take0;
  assign take[1] = take1;

  assign only1 = !rdy[0] && rdy[1];
  assign only0 = rdy[0] && !rdy[1];

  assign bits[0] = only1 ? {s1, s2} : (only0 ? '0 : {s1, {SLOT_W{1'b0}}});
  assign bits[1] = only0 ? {s1, s2} : (only1 ? '0 : {s2, {SLOT_W{1'b0}}});
  assign len[0]  = only1 ? (FW+1)'(PAIR) : (only0 ? '0 : (FW+1)'(SLOT_W));
  assign len[1]  = only0 ? (FW+1)'(PAIR) : (only1 ? '0 : (FW+1)'(SLOT_W));

  assign word_ready = !restart && room[0] && room[1];
  assign acc = word_valid && word_ready;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign rdy[i]  = fill_q[i] >= FW'(NEED);
    assign tk[i]   = (FW'(take[i]) > fill_q[i]) ? fill_q[i] : FW'(take[i]);
    assign rem[i]  = fill_q[i] - tk[i];
    assign room[i] = ((FW+1)'(rem[i]) + len[i]) <= (FW+1)'(BUF_W);

    always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
        win_q[i]  <= '0;
        fill_q[i] <= '0;
      end else begin
        win_q[i]  <= (win_q[i] << tk[i]) |
                     (acc ? ({bits[i], {(BUF_W-PAIR){1'b0}}} >> rem[i]) : '0);
        fill_q[i] <= rem[i] + (acc ? FW'(len[i]) : '0);
      end
    end

    // R10
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q[i] <= FW'(BUF_W));
  end

  assign win0  = win_q[0];
  assign win1  = win_q[1];
  assign fill0 = fill_q[0];
  assign fill1 = fill_q[1];
  assign rdy0  = rdy[0];
  assign rdy1  = rdy[1];

  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (fill0 == '0 && fill1 == '0 && win0 == '0 && win1 == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !acc && take0 == '0 && take1 == '0)
      |=> ($stable(win0) && $stable(win1) && $stable(fill0) && $stable(fill1)));

  // R5
  only1_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rdy0 && rdy1) |=> (fill1 == $past(rem[1]) && fill0 == $past(rem[0]) + FW'(PAIR)));

  // R6
  only0_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rdy0 && !rdy1) |=> (fill0 == $past(rem[0]) && fill1 == $past(rem[1]) + FW'(PAIR)));
endmodule

// File: tb/test_dual_slot_router.sv
module test_dual_slot_router;
  localparam int CLK_NS = 10;
  localparam int NV = 12;

  // {restart, valid, data, take0, take1, exp_ready, exp_win0, exp_win1, exp_fill0, exp_fill1}
  localparam logic [58:0] VEC [NV] = '{
    {1'b0,1'b1,8'hA5,3'd0,3'd0,1'b1,16'hA000,16'h5000,5'd4, 5'd4 },
    {1'b0,1'b1,8'h3C,3'd0,3'd0,1'b1,16'hA300,16'h5C00,5'd8, 5'd8 },
    {1'b0,1'b1,8'hF0,3'd3,3'd5,1'b1,16'h1F80,16'h8000,5'd9, 5'd7 },
    {1'b0,1'b0,8'h00,3'd0,3'd0,1'b1,16'h1F80,16'h8000,5'd9, 5'd7 },
    {1'b0,1'b0,8'h00,3'd5,3'd0,1'b1,16'hF000,16'h8000,5'd4, 5'd7 },
    {1'b0,1'b1,8'h96,3'd0,3'd2,1'b1,16'hF960,16'h0000,5'd12,5'd5 },
    {1'b0,1'b1,8'h11,3'd0,3'd0,1'b1,16'hF961,16'h0080,5'd16,5'd9 },
    {1'b0,1'b1,8'hFF,3'd0,3'd0,1'b0,16'hF961,16'h0080,5'd16,5'd9 },
    {1'b0,1'b0,8'h00,3'd0,3'd5,1'b0,16'hF961,16'h1000,5'd16,5'd4 },
    {1'b0,1'b1,8'hC3,3'd4,3'd0,1'b1,16'h9610,16'h1C30,5'd12,5'd12},
    {1'b1,1'b1,8'hAA,3'd0,3'd0,1'b0,16'h0000,16'h0000,5'd0, 5'd0 },
    {1'b0,1'b1,8'h5A,3'd7,3'd6,1'b1,16'h5000,16'hA000,5'd4, 5'd4 }
  };

  function automatic string tag_of(int k);
    case (k)
      0, 1:    return "R4";
      2:       return "R7/R8";
      3:       return "R10";
      4, 8:    return "R8";
      5:       return "R5";
      6:       return "R7";
      7:       return "R10";
      9:       return "R6";
      10:      return "R2";
      default: return "R9";
    endcase
  endfunction

  logic clk = 0, rst_n = 0, restart = 0, word_valid = 0;
  logic [7:0] word_data = '0;
  logic [2:0] take0 = '0, take1 = '0;
  logic word_ready, rdy0, rdy1;
  logic [15:0] win0, win1;
  logic [4:0] fill0, fill1;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  dual_slot_router i_dual_slot_router (
    .clk(clk), .rst_n(rst_n), .restart(restart), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .take0(take0), .take1(take1),
    .win0(win0), .win1(win1), .fill0(fill0), .fill1(fill1), .rdy0(rdy0), .rdy1(rdy1));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_zero(string tag);
    chk(tag, "fill0", 32'(fill0), 0);
    chk(tag, "fill1", 32'(fill1), 0);
    chk(tag, "win0", 32'(win0), 0);
    chk(tag, "win1", 32'(win1), 0);
    chk(tag, "rdy0", 32'(rdy0), 0);
    chk(tag, "rdy1", 32'(rdy1), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_zero("R1");
    rst_n = 1;
    for (int k = 0; k < NV; k++) begin
      logic [58:0] v;
      v = VEC[k];
      restart    = v[58];
      word_valid = v[57];
      word_data  = v[56:49];
      take0      = v[48:46];
      take1      = v[45:43];
      #1;
      chk(tag_of(k), "word_ready", 32'(word_ready), 32'(v[42]));
      @(negedge clk);
      chk(tag_of(k), "win0", 32'(win0), 32'(v[41:26]));
      chk(tag_of(k), "win1", 32'(win1), 32'(v[25:10]));
      chk(tag_of(k), "fill0", 32'(fill0), 32'(v[9:5]));
      chk(tag_of(k), "fill1", 32'(fill1), 32'(v[4:0]));
      chk("R3", "rdy0", 32'(rdy0), 32'(v[9:5] >= 5));
      chk("R3", "rdy1", 32'(rdy1), 32'(v[4:0] >= 5));
    end
    restart = 0; word_valid = 0; take0 = 0; take1 = 0;
    // R1: reset taken mid-run with both buffers holding bits
    rst_n = 0;
    @(negedge clk);
    chk_zero("R1");
    rst_n = 1;
    // R2: restart with a valid word offered is refused and empties the buffers
    word_valid = 1; word_data = 8'h77;
    @(negedge clk);
    restart = 1;
    #1;
    chk("R2", "word_ready", 32'(word_ready), 0);
    @(negedge clk);
    restart = 0; word_valid = 0;
    chk_zero("R2");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule